// File: doc/BRIEF.md
# EEPROM Write-Status Polling Responder

This block sits in the read path of a byte-wide EEPROM. It tells a host how far an internal write has progressed. While the array is being programmed, a read does not return array contents. It returns a status byte instead:

- the top bit is the complement of the matching bit of the last byte the host loaded;
- a second bit flips between successive reads;
- all other bits are zero.

A separate ready/busy line is modelled as a drive-low enable. It is pulled low from the first write strobe of a cycle until programming ends. After that it is released to high impedance, and reads once again return the array byte presented on `arr_data`.

The write engine supplies two signals: `wr_strobe` (one pulse per accepted write strobe) and `prog_busy` (high while the cells are being programmed). It also supplies `last_byte`, the byte most recently loaded. The host read strobe arrives as `rd_en`, which is high while chip select and output enable are both active. A protect input `res_n` overrides everything. While `res_n` is low the outputs float, no read is served and any write cycle in progress is abandoned.

A small sequencer follows the write cycle through four states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No write in progress |
| `ST_LOAD` | A write strobe has been seen and bytes are still being loaded |
| `ST_PROG` | Internal programming is running |
| `ST_HALT` | The protect input is low |

Its transitions are:

| From | To | Condition |
|------|----|-----------|
| Any state | `ST_HALT` | `res_n` low (checked first) |
| `ST_HALT` | `ST_LOAD` | `res_n` high and `wr_strobe` high |
| `ST_HALT` | `ST_IDLE` | `res_n` high and no strobe |
| `ST_IDLE` | `ST_PROG` | `prog_busy` high (checked before the strobe) |
| `ST_IDLE` | `ST_LOAD` | `wr_strobe` high |
| `ST_LOAD` | `ST_PROG` | `prog_busy` high |
| `ST_PROG` | `ST_IDLE` | `prog_busy` low |

Top module: `eeprom_poll_responder`

## Requirements
- R1: After `rst_n` is released with `rd_en` low, `dout_oe` is 0, `rdy_drive_low` is 0 and `dout` is 8'h00.
- R2: With `res_n` high, a `wr_strobe` pulse while idle makes `rdy_drive_low` go to 1 from the next clock edge on. It stays 1 through loading and programming.
- R3: One clock edge after `prog_busy` falls during programming, `rdy_drive_low` returns to 0.
- R4: A read during programming drives `dout[7]` with the complement of `last_byte[7]`. This starts from the second edge after `prog_busy` rises.
- R5: During programming, `dout[6]` reads 1 on the first read and alternates on each later read. It advances on the clock edge where `rd_en` is seen low after having been high.
- R6: During a status read, `dout[5:0]` is 6'b000000, whatever `arr_data` holds.
- R7: A read while idle or while bytes are still being loaded returns `arr_data` unchanged. After programming ends, a read returns the written byte placed on `arr_data`.
- R8: While `res_n` is low, `dout_oe` is 0 and `dout` is 8'h00 in the same cycle, even with `rd_en` high. `rdy_drive_low` is 0 from the next edge. Once `res_n` is high again and a clock edge has passed, reads return `arr_data`.
- R9: Each new programming phase restarts `dout[6]` at 1 on its first read.
- R10: With `rd_en` low, `dout_oe` is 0 and `dout` is 8'h00 in every state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_n | input | 1 | Protect input; low blocks reads and aborts writes |
| rd_en | input | 1 | Host read strobe (chip select and output enable both active) |
| wr_strobe | input | 1 | One-cycle pulse per accepted write strobe |
| prog_busy | input | 1 | High while the array is being programmed |
| last_byte | input | 8 | Last byte loaded by the host |
| arr_data | input | 8 | Array byte at the current read address |
| dout | output | 8 | Data bus value, zero when not driven |
| dout_oe | output | 1 | Data bus output enable |
| rdy_drive_low | output | 1 | Ready/busy pull-low enable; 0 means high impedance |

## Verification
The assertions assume that `prog_busy` rises only after a write strobe or while idle. They also assume `last_byte` is stable during programming and that `res_n`, `rd_en` and the write-engine inputs are synchronous to `clk`. The bench meets these conditions in several ways:

- every input changes on the falling clock edge;
- `last_byte` is set before `prog_busy` rises;
- each read lasts one cycle and is followed by at least one idle cycle, so every read produces exactly one deassertion edge.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2,
        ST_HALT = 2'd3
    } poll_state_e;

endpackage

// File: rtl/poll_seq_fsm.sv
module poll_seq_fsm
    import poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_n,
    input  logic wr_strobe,
    input  logic prog_busy,
    output logic in_prog,
    output logic busy_low,
    output logic serve_ok
);

    poll_state_e state_q;
    poll_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!res_n) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_HALT: state_d = wr_strobe ? ST_LOAD : ST_IDLE;
                ST_IDLE: begin
                    if (prog_busy)      state_d = ST_PROG;
                    else if (wr_strobe) state_d = ST_LOAD;
                end
                ST_LOAD: if (prog_busy)  state_d = ST_PROG;
                ST_PROG: if (!prog_busy) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        in_prog  = 1'b0;
        busy_low = 1'b0;
        serve_ok = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: busy_low = 1'b1;
            ST_PROG: begin
                busy_low = 1'b1;
                in_prog  = 1'b1;
            end
            ST_HALT: serve_ok = 1'b0;
            default: serve_ok = 1'b0;
        endcase
    end

    AST_HALT_ON_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_n |=> (state_q == ST_HALT)); // R8

    AST_PROG_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> $past(prog_busy)); // R3

endmodule

// File: rtl/poll_toggle.sv
module poll_toggle #(
    parameter logic TOG_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_prog,
    input  logic rd_en,
    output logic tog
);

    logic rd_q;
    logic rd_fall;

    assign rd_fall = rd_q && !rd_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            tog  <= TOG_INIT;
        end else begin
            rd_q <= rd_en;
            if (!in_prog)     tog <= TOG_INIT;
            else if (rd_fall) tog <= ~tog;
        end
    end

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && !rd_fall) |=> $stable(tog) || !in_prog); // R5

    AST_TOGGLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_prog) |-> (tog == TOG_INIT)); // R9

endmodule

// File: rtl/poll_out_mux.sv
module poll_out_mux #(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              rd_en,
    input  logic              res_n,
    input  logic              serve_ok,
    input  logic              in_prog,
    input  logic              tog,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    logic [DATA_W-1:0] status_word;

    // Status byte: inverted polling bit, toggle bit, all other bits zero
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_status
            if (i == POLL_BIT) begin : g_poll
                assign status_word[i] = ~last_byte[i];
            end else if (i == TOG_BIT) begin : g_tog
                assign status_word[i] = tog;
            end else begin : g_zero
                assign status_word[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        dout_oe = rd_en && res_n && serve_ok;
        if (!dout_oe)    dout = '0;
        else if (in_prog) dout = status_word;
        else              dout = arr_data;
    end

endmodule

// File: rtl/eeprom_poll_responder.sv
module eeprom_poll_responder #(
    parameter int   DATA_W   = 8,
    parameter int   POLL_BIT = DATA_W - 1,
    parameter int   TOG_BIT  = DATA_W - 2,
    parameter logic TOG_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_n,
    input  logic              rd_en,
    input  logic              wr_strobe,
    input  logic              prog_busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              rdy_drive_low
);

    logic in_prog;
    logic busy_low;
    logic serve_ok;
    logic tog;

    poll_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_n     (res_n),
        .wr_strobe (wr_strobe),
        .prog_busy (prog_busy),
        .in_prog   (in_prog),
        .busy_low  (busy_low),
        .serve_ok  (serve_ok)
    );

    poll_toggle #(.TOG_INIT(TOG_INIT)) u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_prog (in_prog),
        .rd_en   (rd_en),
        .tog     (tog)
    );

    poll_out_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .rd_en     (rd_en),
        .res_n     (res_n),
        .serve_ok  (serve_ok),
        .in_prog   (in_prog),
        .tog       (tog),
        .last_byte (last_byte),
        .arr_data  (arr_data),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assign rdy_drive_low = busy_low;

    AST_RDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && res_n && !rdy_drive_low) |=> (rdy_drive_low || !res_n)); // R2

    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prog_busy) && $past(res_n) && rdy_drive_low) |=> !rdy_drive_low); // R3

    AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && prog_busy && $past(prog_busy) && $past(res_n))
        |-> (dout[POLL_BIT] != last_byte[POLL_BIT])); // R4

    AST_PROTECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(res_n) |=> !rdy_drive_low); // R8

    AST_FLOAT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (!dout_oe && (dout == '0))); // R10

    AST_ARRAY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !rdy_drive_low) |-> (dout == arr_data)); // R7

endmodule

// File: tb/test_eeprom_poll_responder.sv
module test_eeprom_poll_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_n = 1'b1;
    logic       rd_en = 1'b0;
    logic       wr_strobe = 1'b0;
    logic       prog_busy = 1'b0;
    logic [7:0] last_byte = 8'h00;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic       rdy_drive_low;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_poll_responder i_eeprom_poll_responder (
        .clk           (clk),
        .rst_n         (rst_n),
        .res_n         (res_n),
        .rd_en         (rd_en),
        .wr_strobe     (wr_strobe),
        .prog_busy     (prog_busy),
        .last_byte     (last_byte),
        .arr_data      (arr_data),
        .dout          (dout),
        .dout_oe       (dout_oe),
        .rdy_drive_low (rdy_drive_low)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one-cycle read, then one idle cycle; sample mid-read
    task automatic do_read(output logic [7:0] val, output logic oe);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        val = dout;
        oe  = dout_oe;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk);
        wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 oe", {7'd0, dout_oe}, 8'h00);
        chk("R1 rdy", {7'd0, rdy_drive_low}, 8'h00);
        chk("R1 dout", dout, 8'h00);
    endtask

    task automatic t_idle_read();
        logic [7:0] v;
        logic oe;
        arr_data = 8'h3C;
        do_read(v, oe);
        chk("R7 idle oe", {7'd0, oe}, 8'h01);
        chk("R7 idle data", v, 8'h3C);
        #1;
        chk("R10 no read oe", {7'd0, dout_oe}, 8'h00);
        chk("R10 no read dout", dout, 8'h00);
    endtask

    task automatic t_write_poll(input logic [7:0] lb, input logic [7:0] arr);
        logic [7:0] v;
        logic oe;
        strobe();
        chk("R2 rdy after strobe", {7'd0, rdy_drive_low}, 8'h01);
        arr_data = 8'h5A;
        do_read(v, oe);
        chk("R7 load-phase read", v, 8'h5A);
        last_byte = lb;
        arr_data  = 8'hFF;
        prog_busy = 1'b1;
        step();
        step();
        for (int k = 0; k < 3; k++) begin
            do_read(v, oe);
            chk("R4 poll bit", {7'd0, v[7]}, {7'd0, ~lb[7]});
            chk((k == 0) ? "R9 toggle start" : "R5 toggle", {7'd0, v[6]}, {7'd0, ~k[0]});
            chk("R6 low bits", {2'b00, v[5:0]}, 8'h00);
        end
        chk("R2 rdy during prog", {7'd0, rdy_drive_low}, 8'h01);
        #1;
        chk("R10 no read in prog", dout, 8'h00);
        @(negedge clk);
        prog_busy = 1'b0;
        @(negedge clk);
        #1;
        chk("R3 rdy released", {7'd0, rdy_drive_low}, 8'h00);
        arr_data = arr;
        do_read(v, oe);
        chk("R7 data after write", v, arr);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        logic oe;
        strobe();
        last_byte = 8'h80;
        prog_busy = 1'b1;
        step();
        step();
        @(negedge clk);
        res_n = 1'b0;
        rd_en = 1'b1;
        #1;
        chk("R8 oe blocked", {7'd0, dout_oe}, 8'h00);
        chk("R8 dout float", dout, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        chk("R8 rdy released", {7'd0, rdy_drive_low}, 8'h00);
        prog_busy = 1'b0;
        @(negedge clk);
        res_n = 1'b1;
        arr_data = 8'h66;
        step();
        do_read(v, oe);
        chk("R8 read after protect", v, 8'h66);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_write_poll(8'hA5, 8'hA5);
        t_write_poll(8'h12, 8'h12);
        t_protect();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule